// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Check

This block holds recently used translations from virtual page numbers to physical page numbers. Every stored translation is compared at once against the page number of the incoming virtual address. On a match, the block returns the physical address in the same cycle. That address is the stored physical page number joined to the unchanged page offset. In the same cycle the block judges the access type against the entry's permission bits and the current privilege level.

On a lookup that finds no match, the block raises a miss output. An outside page walker then loads the translation through the refill port. When every slot is in use, a new translation overwrites the slot that was filled longest ago. A build option can choose a pseudo-random slot instead. A flush input empties the whole buffer when the address space changes.

Stores mark their page dirty. The dirty state of the matched entry is reported with each lookup, so the walker knows when the page table entry needs updating.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no entry is valid: every lookup reports a miss, with hit, fault and dirty low.
- R2: A lookup whose page number (address bits [31:12]) matches a valid entry raises hit in the same cycle and drives a physical address equal to the stored page number in bits [31:12] with the lookup's address bits [11:0] copied unchanged.
- R3: A lookup with no matching valid entry raises miss and keeps hit low. Whenever a lookup is presented, exactly one of hit and miss is high.
- R4: A refill presented on one clock edge makes its translation visible to lookups from the next cycle on. A refill installs its entry with the dirty bit clear.
- R5: In user mode (user input high), a load to an entry without read permission, or a store to an entry without write permission, raises fault together with hit. In kernel mode, no permission fault is raised. Fault is never high without hit.
- R6: A store that hits without a fault sets the entry's dirty bit. The dirty output shows the matched entry's dirty bit as it stood before the access.
- R7: A store that raises a fault leaves the entry's dirty bit unchanged.
- R8: A refill whose page number matches a valid entry overwrites that entry in place. No second copy is made, and the replacement order does not advance.
- R9: With FIFO replacement, refills of new page numbers fill slots in order from the last reset or flush. Once all slots are full, each new refill evicts the oldest remaining translation and keeps all the others.
- R10: A flush makes every entry invalid, so all lookups in the next cycle miss.
- R11: When flush and refill coincide, the flush takes effect and the refill is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Matching valid translation found |
| lk_miss | output | 1 | No translation found; walk needed |
| lk_fault | output | 1 | Permission denied on a hit |
| lk_dirty | output | 1 | Dirty bit of the matched entry before this access |
| lk_paddr | output | 32 | Translated physical address |
| fill_en | input | 1 | Install a translation on this edge |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_rd | input | 1 | Read permission of the new entry |
| fill_wr | input | 1 | Write permission of the new entry |
| flush | input | 1 | Invalidate all entries |

## Verification
Lookups are applied with matching and non-matching page numbers and with several different offsets. This shows that the offset passes through untouched and that hit and miss are exclusive. The four combinations of load or store, read or write permission and user or kernel mode separate permission faults from privileged bypass. A later lookup then shows whether the dirty bit moved. The buffer is filled to capacity and one slot beyond it, before and after an in-place overwrite. This tells strict first-in eviction apart from an order disturbed by duplicate refills. Flush is tried alone and together with a refill, to confirm that the flush wins.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic {
      REPL_FIFO = 1'b0,
      REPL_LFSR = 1'b1
   } repl_e;

   localparam int MIN_SLOTS = 32;
   localparam int MAX_SLOTS = 128;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int N     = 32,
   parameter int TAG_W = 20,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     valid_i,
   input  logic [TAG_W-1:0] tag_i [N],
   input  logic [TAG_W-1:0] key_i,
   output logic [N-1:0]     vec_o,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign vec_o[g] = valid_i[g] && (tag_i[g] == key_i);
   end

   assign any_o = |vec_o;

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (vec_o[i]) idx_o = idx_o | IDX_W'(i);
      end
   end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
   import tlb_pkg::*;
#(
   parameter int    N     = 32,
   parameter int    IDX_W = $clog2(N),
   parameter repl_e MODE  = REPL_FIFO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             advance_i,
   output logic [IDX_W-1:0] idx_o
);
   if (MODE == REPL_FIFO) begin : g_fifo
      logic [IDX_W-1:0] ptr_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clear_i) ptr_q <= '0;
         else if (advance_i) ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
      end
      assign idx_o = ptr_q;

      // R9
      fifo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (advance_i && !clear_i) |=>
            (idx_o == (($past(idx_o) == IDX_W'(N - 1)) ? '0 : $past(idx_o) + 1'b1)));
   end else begin : g_lfsr
      logic [15:0] lfsr_q;
      always_ff @(posedge clk) begin
         if (!rst_n) lfsr_q <= 16'hACE1;
         else if (advance_i) lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
      end
      assign idx_o = IDX_W'(lfsr_q % 16'(N));
   end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int    VPN_W   = 20,
   parameter int    OFS_W   = 12,
   parameter int    PPN_W   = 20,
   parameter int    ENTRIES = 32,
   parameter repl_e REPL    = REPL_FIFO,
   localparam int   VA_W    = VPN_W + OFS_W,
   localparam int   PA_W    = PPN_W + OFS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic             lk_store,
   input  logic             lk_user,
   output logic             lk_hit,
   output logic             lk_miss,
   output logic             lk_fault,
   output logic             lk_dirty,
   output logic [PA_W-1:0]  lk_paddr,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_rd,
   input  logic             fill_wr,
   input  logic             flush
);
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < MIN_SLOTS || ENTRIES > MAX_SLOTS) begin : g_bad_entries
      $error("tlb_xlate: ENTRIES outside supported range");
   end
   if (VPN_W < 1 || PPN_W < 1 || OFS_W < 1) begin : g_bad_widths
      $error("tlb_xlate: field widths must be positive");
   end

   logic [ENTRIES-1:0] v_q, rd_q, wr_q, d_q;
   logic [VPN_W-1:0]   tag_q [ENTRIES];
   logic [PPN_W-1:0]   ppn_q [ENTRIES];

   logic [VPN_W-1:0]   lk_vpn;
   logic [ENTRIES-1:0] lk_vec, fl_vec;
   logic               lk_any, fl_any;
   logic [IDX_W-1:0]   lk_idx, fl_idx, vic_idx, wr_idx;
   logic               deny, set_dirty, alloc;

   assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];

   tlb_match #(.N(ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
      .valid_i(v_q), .tag_i(tag_q), .key_i(lk_vpn),
      .vec_o(lk_vec), .any_o(lk_any), .idx_o(lk_idx)
   );

   tlb_match #(.N(ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_fl_match (
      .valid_i(v_q), .tag_i(tag_q), .key_i(fill_vpn),
      .vec_o(fl_vec), .any_o(fl_any), .idx_o(fl_idx)
   );

   assign alloc = fill_en && !flush && !fl_any;

   tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W), .MODE(REPL)) u_victim (
      .clk(clk), .rst_n(rst_n), .clear_i(flush),
      .advance_i(alloc), .idx_o(vic_idx)
   );

   // lookup and access check
   assign lk_hit   = lk_valid && lk_any;
   assign lk_miss  = lk_valid && !lk_any;
   assign deny     = lk_user && (lk_store ? !wr_q[lk_idx] : !rd_q[lk_idx]);
   assign lk_fault = lk_hit && deny;
   assign lk_dirty = lk_hit && d_q[lk_idx];
   assign lk_paddr = {ppn_q[lk_idx], lk_vaddr[OFS_W-1:0]};

   assign set_dirty = lk_hit && lk_store && !deny;
   assign wr_idx    = fl_any ? fl_idx : vic_idx;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         v_q <= '0;
      end else begin
         if (set_dirty) d_q[lk_idx] <= 1'b1;
         if (fill_en) begin
            v_q[wr_idx]   <= 1'b1;
            rd_q[wr_idx]  <= fill_rd;
            wr_q[wr_idx]  <= fill_wr;
            d_q[wr_idx]   <= 1'b0;
            tag_q[wr_idx] <= fill_vpn;
            ppn_q[wr_idx] <= fill_ppn;
         end
      end
   end

   // R3
   hit_miss_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (lk_hit != lk_miss));
   // R5
   fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_hit);
   // R8
   no_dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_vec));
   // R10
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit);
   // R4
   fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !flush) |=> (!(lk_valid && lk_vpn == $past(fill_vpn)) || lk_hit));
   // R6
   dirty_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_dirty && !flush && !fill_en) |=>
         (!(lk_valid && lk_vpn == $past(lk_vpn)) || lk_dirty));
endmodule

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_valid, lk_store, lk_user;
   logic [31:0] lk_vaddr;
   logic        lk_hit, lk_miss, lk_fault, lk_dirty;
   logic [31:0] lk_paddr;
   logic        fill_en, fill_rd, fill_wr, flush;
   logic [19:0] fill_vpn, fill_ppn;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic        r_hit, r_miss, r_fault, r_dirty;
   logic [31:0] r_pa;

   always #4 clk = ~clk;

   tlb_xlate #(.ENTRIES(N)) u_tlb_xlate (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_store(lk_store), .lk_user(lk_user),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_dirty(lk_dirty),
      .lk_paddr(lk_paddr),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_rd(fill_rd), .fill_wr(fill_wr), .flush(flush)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic look(input logic [31:0] va, input logic st, input logic usr);
      @(negedge clk);
      lk_valid = 1'b1; lk_vaddr = va; lk_store = st; lk_user = usr;
      #1;
      r_hit = lk_hit; r_miss = lk_miss; r_fault = lk_fault; r_dirty = lk_dirty; r_pa = lk_paddr;
      @(negedge clk);
      lk_valid = 1'b0; lk_store = 1'b0;
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                       input logic rd, input logic wr, input logic fl);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rd = rd; fill_wr = wr; flush = fl;
      @(negedge clk);
      fill_en = 1'b0; flush = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic t_reset();
      look(32'h0000_0000, 1'b0, 1'b0);
      check("R1 hit", r_hit, 0);
      check("R1 miss", r_miss, 1);
      check("R1 fault", r_fault, 0);
      check("R1 dirty", r_dirty, 0);
   endtask

   task automatic t_hit_miss();
      fill(20'h12345, 20'hABCDE, 1'b1, 1'b1, 1'b0);
      look(32'h1234_5678, 1'b0, 1'b1);
      check("R4 visible", r_hit, 1);
      check("R2 paddr", r_pa, 32'hABCD_E678);
      check("R4 dirty clear", r_dirty, 0);
      look(32'h1234_5FFF, 1'b0, 1'b0);
      check("R2 offset", r_pa, 32'hABCD_EFFF);
      check("R3 not miss", r_miss, 0);
      look(32'h1234_6000, 1'b0, 1'b1);
      check("R3 miss", r_miss, 1);
      check("R3 no hit", r_hit, 0);
   endtask

   task automatic t_perm();
      fill(20'h00100, 20'h00AAA, 1'b0, 1'b0, 1'b0);
      look(32'h0010_0004, 1'b0, 1'b1);
      check("R5 user load no rd", r_fault, 1);
      check("R5 fault with hit", r_hit, 1);
      look(32'h0010_0004, 1'b1, 1'b1);
      check("R5 user store no wr", r_fault, 1);
      look(32'h0010_0004, 1'b0, 1'b0);
      check("R7 dirty untouched", r_dirty, 0);
      check("R5 kernel load", r_fault, 0);
      look(32'h0010_0008, 1'b1, 1'b0);
      check("R5 kernel store", r_fault, 0);
      check("R6 dirty before", r_dirty, 0);
      look(32'h0010_0008, 1'b0, 1'b0);
      check("R6 kernel store dirty", r_dirty, 1);
      fill(20'h00200, 20'h00BBB, 1'b1, 1'b0, 1'b0);
      look(32'h0020_0000, 1'b0, 1'b1);
      check("R5 user load rd ok", r_fault, 0);
      look(32'h0020_0000, 1'b1, 1'b1);
      check("R5 user store ro", r_fault, 1);
      look(32'h0020_0000, 1'b0, 1'b1);
      check("R7 ro page clean", r_dirty, 0);
      fill(20'h00300, 20'h00CCC, 1'b1, 1'b1, 1'b0);
      look(32'h0030_0010, 1'b1, 1'b1);
      check("R6 store no fault", r_fault, 0);
      check("R6 dirty was clear", r_dirty, 0);
      look(32'h0030_0010, 1'b0, 1'b1);
      check("R6 dirty set", r_dirty, 1);
   endtask

   task automatic t_flush();
      fill(20'h00400, 20'h00DDD, 1'b1, 1'b1, 1'b0);
      do_flush();
      look(32'h0040_0000, 1'b0, 1'b0);
      check("R10 flushed", r_hit, 0);
      look(32'h1234_5000, 1'b0, 1'b0);
      check("R10 flushed older", r_miss, 1);
      fill(20'h00500, 20'h00EEE, 1'b1, 1'b1, 1'b0);
      fill(20'h00600, 20'h00FFF, 1'b1, 1'b1, 1'b1);
      look(32'h0050_0000, 1'b0, 1'b0);
      check("R11 flush wins", r_hit, 0);
      look(32'h0060_0000, 1'b0, 1'b0);
      check("R11 fill dropped", r_hit, 0);
   endtask

   task automatic t_fifo();
      int bad = 0;
      do_flush();
      for (int i = 0; i < N; i++) fill(20'h01000 + 20'(i), 20'h20000 + 20'(i), 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < N; i++) begin
         look({20'h01000 + 20'(i), 12'h000}, 1'b0, 1'b0);
         if (!r_hit || r_pa[31:12] != 20'h20000 + 20'(i)) bad++;
      end
      check("R9 all slots held", bad, 0);
      fill(20'h02000, 20'h30000, 1'b1, 1'b1, 1'b0);
      look(32'h0100_0000, 1'b0, 1'b0);
      check("R9 oldest evicted", r_hit, 0);
      look(32'h0100_1000, 1'b0, 1'b0);
      check("R9 second kept", r_hit, 1);
      look(32'h0200_0000, 1'b0, 1'b0);
      check("R9 new present", r_pa, 32'h3000_0000);
   endtask

   task automatic t_overwrite();
      do_flush();
      fill(20'h03000, 20'h00001, 1'b1, 1'b1, 1'b0);
      fill(20'h03000, 20'h00002, 1'b1, 1'b1, 1'b0);
      look(32'h0300_0123, 1'b0, 1'b0);
      check("R8 overwritten", r_pa, 32'h0000_2123);
      for (int i = 1; i < N; i++) fill(20'h04000 + 20'(i), 20'h1000 + 20'(i), 1'b1, 1'b1, 1'b0);
      look(32'h0300_0000, 1'b0, 1'b0);
      check("R8 no slot used", r_hit, 1);
      fill(20'h05000, 20'h00009, 1'b1, 1'b1, 1'b0);
      look(32'h0300_0000, 1'b0, 1'b0);
      check("R8 evicted next", r_hit, 0);
      look(32'h0400_1000, 1'b0, 1'b0);
      check("R8 others kept", r_hit, 1);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_store = 1'b0; lk_user = 1'b0;
      fill_en = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_rd = 1'b0; fill_wr = 1'b0; flush = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_hit_miss();
      t_perm();
      t_flush();
      t_fifo();
      t_overwrite();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule